// File: doc/BRIEF.md
# Reset Strap Capture and Address/GPIO Pin Multiplexer

This block samples a set of configuration strap inputs while the chip is held in reset and freezes them once reset is released. The frozen values give the boot source of the main processor, whether the coprocessor boots itself or is booted by the main processor, and the width of the external memory data bus. These values stay fixed until the next reset.

A 5-bit address-width code is also captured. Unlike the other straps, it lands in a field that software can rewrite after reset. The block turns this code into a 23-bit enable mask over a shared group of external pins. A pin whose mask bit is set carries a memory address, with its output data and output enable taken from the memory controller. Every other pin belongs to general-purpose I/O.

The enabled address pins form a contiguous run that starts at pin 0. Pins 2 and 3 are an exception: they act as the NAND latch-enable strobes and are enabled in every setting. As a result, widths 2, 3 and 4 all give four address pins, and width 0 still leaves the two strobes for NAND access.

Top module: `strap_pinmux`

## Requirements
- R1: Each strap register follows its strap input at every clock edge while `rst_n` is low. From the first clock edge with `rst_n` high, the boot, coprocessor and bus-width outputs hold the value from the last edge in reset, and later strap changes have no effect on them.
- R2: `boot_sel` is one-hot for the captured 2-bit boot code: code 00 sets bit 0 (ROM boot from NAND), 01 sets bit 1 (external NOR bus), 10 sets bit 2 (host port), 11 sets bit 3 (ROM boot over UART).
- R3: `cop_self_boot` is 1 when the captured coprocessor strap was 1 (coprocessor boots itself) and 0 when it was 0 (main processor boots the coprocessor).
- R4: `bus16` is 1 when the captured width strap was 1 (16-bit data bus) and 0 when it was 0 (8-bit data bus).
- R5: After reset, `aw_field` holds the captured 5-bit address-width strap. After a write it returns the written value unchanged, including values 24 to 31.
- R6: `addr_en[i]` is 1 when i is below the effective width w, and also for i = 2 and i = 3. All other bits are 0.
- R7: Width values 24 to 31 are treated as w = 23, so all 23 mask bits are 1.
- R8: A cycle with `wr_en` high, `rst_n` high and `wr_addr` equal to `MUX_ADDR` (default 0) loads `wr_data` into `aw_field`. The new field and mask are visible after that clock edge. A write to any other address leaves the field and mask unchanged.
- R9: For each pin i, `pin_out[i]`/`pin_oe[i]` equal `emif_do[i]`/`emif_oe[i]` when `addr_en[i]` is 1, and `gpio_do[i]`/`gpio_oe[i]` otherwise.
- R10: Widths 2, 3 and 4 each enable exactly four pins (bits 0 to 3). Width 0 enables only bits 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; straps are frozen when it goes high |
| strap_boot | input | 2 | Main processor boot select strap |
| strap_cop_self | input | 1 | Coprocessor self-boot strap |
| strap_bus16 | input | 1 | External data bus width strap |
| strap_aw | input | 5 | Address-width strap |
| wr_en | input | 1 | Register write valid |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 5 | Register write data (address-width field) |
| emif_do | input | 23 | Memory controller output data per pin |
| emif_oe | input | 23 | Memory controller output enable per pin |
| gpio_do | input | 23 | GPIO output data per pin |
| gpio_oe | input | 23 | GPIO output enable per pin |
| boot_sel | output | 4 | One-hot boot source |
| cop_self_boot | output | 1 | Coprocessor boots itself |
| bus16 | output | 1 | 16-bit external data bus |
| aw_field | output | 5 | Address-width field readback |
| addr_en | output | 23 | Per-pin address enable mask |
| pin_out | output | 23 | Muxed pin output data |
| pin_oe | output | 23 | Muxed pin output enable |

## Verification
The bench sweeps all 32 width codes through the register port. This exposes a design that clamps wrongly at 23 or above, drops the forced strobe pins at width 0 or 1, or enables a fifth pin at widths 2 to 4. It changes the straps right after reset release to catch registers that keep tracking the pins. It also writes to a foreign address to catch a loose address decode. A pin-mux pattern with different memory and GPIO values shows any pin that takes its output from the wrong source.

// File: rtl/strap_pinmux.sv
module strap_pinmux #(
  parameter int NPINS    = 23,
  parameter int AWB      = 5,
  parameter int RA_W     = 4,
  parameter logic [RA_W-1:0] MUX_ADDR = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       strap_boot,
  input  logic             strap_cop_self,
  input  logic             strap_bus16,
  input  logic [AWB-1:0]   strap_aw,
  input  logic             wr_en,
  input  logic [RA_W-1:0]  wr_addr,
  input  logic [AWB-1:0]   wr_data,
  input  logic [NPINS-1:0] emif_do,
  input  logic [NPINS-1:0] emif_oe,
  input  logic [NPINS-1:0] gpio_do,
  input  logic [NPINS-1:0] gpio_oe,
  output logic [3:0]       boot_sel,
  output logic             cop_self_boot,
  output logic             bus16,
  output logic [AWB-1:0]   aw_field,
  output logic [NPINS-1:0] addr_en,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  localparam int STB_A = 2;
  localparam int STB_B = 3;

  logic [1:0]     boot_q;
  logic           cop_q, bus_q;
  logic [AWB-1:0] aw_q;
  logic [31:0]    w_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q <= strap_boot;
      cop_q  <= strap_cop_self;
      bus_q  <= strap_bus16;
      aw_q   <= strap_aw;
    end else if (wr_en && wr_addr == MUX_ADDR) begin
      aw_q   <= wr_data;
    end
  end

  assign boot_sel      = 4'b0001 << boot_q;
  assign cop_self_boot = cop_q;
  assign bus16         = bus_q;
  assign aw_field      = aw_q;
  assign w_eff = (32'(aw_q) > 32'(NPINS)) ? 32'(NPINS) : 32'(aw_q);

  always_comb begin
    for (int i = 0; i < NPINS; i++)
      addr_en[i] = (32'(i) < w_eff) || (i == STB_A) || (i == STB_B);
  end

  assign pin_out = (addr_en & emif_do) | (~addr_en & gpio_do);
  assign pin_oe  = (addr_en & emif_oe) | (~addr_en & gpio_oe);
endmodule

module strap_pinmux_chk #(
  parameter int NPINS = 23,
  parameter int AWB   = 5,
  parameter int RA_W  = 4,
  parameter logic [RA_W-1:0] MUX_ADDR = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [RA_W-1:0]  wr_addr,
  input logic [AWB-1:0]   wr_data,
  input logic [NPINS-1:0] emif_do,
  input logic [NPINS-1:0] gpio_do,
  input logic [3:0]       boot_sel,
  input logic             cop_self_boot,
  input logic             bus16,
  input logic [AWB-1:0]   aw_field,
  input logic [NPINS-1:0] addr_en,
  input logic [NPINS-1:0] pin_out
);
  // R1
  straps_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(boot_sel) && $stable(cop_self_boot) && $stable(bus16)));

  // R2
  boot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(boot_sel) == 1);

  // R8
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == MUX_ADDR) |=> (aw_field == $past(wr_data)));

  // R8
  write_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == MUX_ADDR) |=> ($stable(aw_field) && $stable(addr_en)));

  // R7
  wide_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(aw_field) >= 32'(NPINS)) |-> (&addr_en));

  // R10
  narrow_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_field >= 2 && aw_field <= 4) |-> ($countones(addr_en) == 4));

  // R9
  full_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&addr_en) |-> (pin_out == emif_do));

  // R9
  gpio_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_field == 0) |-> (pin_out[NPINS-1:4] == gpio_do[NPINS-1:4]));
endmodule

bind strap_pinmux strap_pinmux_chk #(.NPINS(NPINS), .AWB(AWB), .RA_W(RA_W), .MUX_ADDR(MUX_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .emif_do(emif_do), .gpio_do(gpio_do), .boot_sel(boot_sel),
  .cop_self_boot(cop_self_boot), .bus16(bus16), .aw_field(aw_field),
  .addr_en(addr_en), .pin_out(pin_out)
);

// File: tb/strap_pinmux_bench.sv
module strap_pinmux_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  strap_boot = 0;
  logic        strap_cop_self = 0, strap_bus16 = 0;
  logic [4:0]  strap_aw = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = 0;
  logic [4:0]  wr_data = 0;
  logic [22:0] emif_do = 0, emif_oe = 0, gpio_do = 0, gpio_oe = 0;
  logic [3:0]  boot_sel;
  logic        cop_self_boot, bus16;
  logic [4:0]  aw_field;
  logic [22:0] addr_en, pin_out, pin_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_pinmux u_strap_pinmux (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [22:0] ref_mask(int code);
    int w = (code > 23) ? 23 : code;
    logic [22:0] m;
    for (int i = 0; i < 23; i++) m[i] = (i < w) || (i == 2) || (i == 3);
    return m;
  endfunction

  task automatic do_reset(logic [1:0] b, logic c, logic s, logic [4:0] a);
    @(negedge clk);
    rst_n = 0; strap_boot = b; strap_cop_self = c; strap_bus16 = s; strap_aw = a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic reg_write(logic [3:0] addr, logic [4:0] data);
    wr_en = 1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic t_reset_state();
    do_reset(2'b10, 1'b1, 1'b0, 5'd7);
    check("R2 boot_sel after reset", 32'(boot_sel), 32'h4);
    check("R3 cop_self_boot after reset", 32'(cop_self_boot), 32'd1);
    check("R4 bus16 after reset", 32'(bus16), 32'd0);
    check("R5 aw_field from strap", 32'(aw_field), 32'd7);
    check("R6 mask from strap", 32'(addr_en), 32'(ref_mask(7)));
  endtask

  task automatic t_strap_hold();
    do_reset(2'b01, 1'b0, 1'b1, 5'd12);
    strap_boot = 2'b11; strap_cop_self = 1; strap_bus16 = 0; strap_aw = 5'd3;
    repeat (3) @(negedge clk);
    check("R1 boot held", 32'(boot_sel), 32'h2);
    check("R1 cop held", 32'(cop_self_boot), 32'd0);
    check("R1 bus16 held", 32'(bus16), 32'd1);
    check("R1 aw held", 32'(aw_field), 32'd12);
  endtask

  task automatic t_boot_codes();
    for (int k = 0; k < 4; k++) begin
      do_reset(2'(k), k[0], k[1], 5'd0);
      check("R2 boot one-hot", 32'(boot_sel), 32'(1 << k));
      check("R3 cop strap", 32'(cop_self_boot), 32'(k & 1));
      check("R4 bus strap", 32'(bus16), 32'((k >> 1) & 1));
    end
  endtask

  task automatic t_width_sweep();
    do_reset(2'b00, 0, 0, 5'd23);
    for (int w = 0; w < 32; w++) begin
      reg_write(4'd0, 5'(w));
      check("R5 readback", 32'(aw_field), 32'(w));
      if (w >= 23) check("R7 clamp all ones", 32'(addr_en), 32'h7FFFFF);
      else if (w <= 4) check("R10 narrow width", 32'(addr_en), 32'(ref_mask(w)));
      else check("R6 contiguous mask", 32'(addr_en), 32'(ref_mask(w)));
    end
    reg_write(4'd0, 5'd0);
    check("R10 width 0 strobes only", 32'(addr_en), 32'hC);
    reg_write(4'd0, 5'd1);
    check("R6 width 1", 32'(addr_en), 32'hD);
  endtask

  task automatic t_write_other();
    do_reset(2'b00, 0, 0, 5'd9);
    reg_write(4'd5, 5'd20);
    check("R8 foreign address field", 32'(aw_field), 32'd9);
    check("R8 foreign address mask", 32'(addr_en), 32'(ref_mask(9)));
    reg_write(4'd0, 5'd20);
    check("R8 own address loads", 32'(addr_en), 32'(ref_mask(20)));
  endtask

  task automatic t_pin_mux();
    do_reset(2'b00, 0, 0, 5'd6);
    emif_do = 23'h2AAAAA; emif_oe = 23'h7FFFFF;
    gpio_do = 23'h555555; gpio_oe = 23'h000000;
    @(negedge clk);
    check("R9 pin_out", 32'(pin_out), 32'((23'h2AAAAA & 23'h3F) | (23'h555555 & ~23'h3F)));
    check("R9 pin_oe", 32'(pin_oe), 32'h3F);
    reg_write(4'd0, 5'd0);
    check("R9 pin_oe width 0", 32'(pin_oe), 32'hC);
  endtask

  initial begin
    t_reset_state();
    t_strap_hold();
    t_boot_codes();
    t_width_sweep();
    t_write_other();
    t_pin_mux();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule